// File: doc/BRIEF.md
# On-demand clock modulation controller

This block throttles one processor core by gating its clock-enable so that the core only advances for a programmed share of each modulation window. Every logical thread that shares the core owns a small control register holding an enable flag and a duty code. Software writes and reads these registers through a plain register port: one write per cycle, and a readback path that needs no handshake.

The per-thread settings are merged into one effective duty. Modulation happens only when every thread has set its enable flag. When the enabled threads disagree, a policy pin picks either the largest or the smallest duty code. A capability strap chooses between a coarse 3-bit duty in eighths and a fine 4-bit duty in sixteenths. The merged setting is taken up only at the boundary of a 16-cycle window, so no window is ever cut short. A core package places one instance of the block per core.

Top module: `clkmod_ctrl`

## Requirements
- R1: Each thread has its own control register. A write to thread `wr_tid` updates only that thread's register. `rd_data` shows, with no delay, the register of the thread selected by `rd_tid`.
- R2: Bits 7:5 of every register read as zero, and write data in those bits is discarded.
- R3: While `ext_cap` is low, bit 0 is dropped on write and reads as zero. The duty in sixteenths is then bits 3:1 times two, which gives steps of 1/8.
- R4: While `ext_cap` is high, the duty in sixteenths is bits 3:0, with bit 0 as the least significant bit. This gives steps of 1/16, up to 15/16.
- R5: Bit 4 is the thread's enable flag. If any thread has it clear, `clk_en` stays high for the whole window and `mod_active` is 0.
- R6: When all threads are enabled, `pol_max`=1 selects the largest per-thread duty and `pol_max`=0 selects the smallest.
- R7: A selected duty of zero gives no modulation: `clk_en` stays high and `mod_active` is 0.
- R8: While modulating with duty N, each 16-cycle window holds `clk_en` high for its first N cycles and low for the remaining 16-N cycles. `eff_duty` reports N.
- R9: Register writes are stored at once. The merged setting, `mod_active` and `eff_duty` change only at a window boundary, which occurs every 16 cycles counted from reset release.
- R10: After reset, all registers read zero, `clk_en` is high and `mod_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_cap | input | 1 | Strap: fine 4-bit duty is supported |
| pol_max | input | 1 | Merge policy: 1 = largest duty, 0 = smallest duty |
| wr_en | input | 1 | Register write strobe |
| wr_tid | input | TID_W | Thread addressed by the write |
| wr_data | input | 8 | Write data |
| rd_tid | input | TID_W | Thread addressed by the readback |
| rd_data | output | 8 | Readback of the selected thread's register |
| clk_en | output | 1 | Gated clock-enable for the core |
| mod_active | output | 1 | Modulation is applied in the current window |
| eff_duty | output | 4 | Duty in sixteenths applied in the current window |

## Verification
The hardest case to reach is a register write that lands in the middle of a window. The pattern must stay as it was until the boundary and switch cleanly at the next one. The bench keeps its own cycle count from reset release. It uses that count to place writes at chosen offsets inside a window, including the last cycle before a boundary. For each window, a scoreboard entry is formed from the register state held just before the boundary edge. Disagreeing threads, a zero duty in one thread and a strap change between writes are each set up to exercise both merge policies and both duty precisions.

// File: rtl/clkmod_pkg.sv
package clkmod_pkg;
  localparam int REG_W  = 8;
  localparam int DUTY_W = 4;
  localparam int WIN_LEN = 1 << DUTY_W;

  typedef struct packed {
    logic       en;
    logic [2:0] coarse;
    logic       fine;
  } ctl_t;

  // Duty expressed in window cycles (sixteenths).
  function automatic logic [DUTY_W-1:0] duty_of(input ctl_t c, input logic ext);
    return {c.coarse, ext ? c.fine : 1'b0};
  endfunction

  function automatic logic [REG_W-1:0] pack_rd(input ctl_t c, input logic ext);
    return {3'b000, c.en, c.coarse, ext ? c.fine : 1'b0};
  endfunction
endpackage

// File: rtl/clkmod_regfile.sv
module clkmod_regfile
  import clkmod_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ext_cap,
  input  logic                          wr_en,
  input  logic [TID_W-1:0]              wr_tid,
  input  logic [REG_W-1:0]              wr_data,
  input  logic [TID_W-1:0]              rd_tid,
  output logic [REG_W-1:0]              rd_data,
  output logic [NUM_THREADS-1:0]        en_vec,
  output logic [NUM_THREADS-1:0][DUTY_W-1:0] duty_vec
);
  ctl_t regs [NUM_THREADS];

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[t] <= '0;
      end else if (wr_en && (wr_tid == TID_W'(t))) begin
        regs[t].en     <= wr_data[4];
        regs[t].coarse <= wr_data[3:1];
        regs[t].fine   <= ext_cap & wr_data[0];
      end
    end
    assign en_vec[t]   = regs[t].en;
    assign duty_vec[t] = duty_of(regs[t], ext_cap);
  end

  always_comb begin
    rd_data = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (rd_tid == TID_W'(t)) rd_data = pack_rd(regs[t], ext_cap);
    end
  end
endmodule

// File: rtl/clkmod_merge.sv
module clkmod_merge
  import clkmod_pkg::*;
#(
  parameter int NUM_THREADS = 2
) (
  input  logic                               pol_max,
  input  logic [NUM_THREADS-1:0]             en_vec,
  input  logic [NUM_THREADS-1:0][DUTY_W-1:0] duty_vec,
  output logic                               req_active,
  output logic [DUTY_W-1:0]                  req_duty
);
  logic [DUTY_W-1:0] hi, lo;

  always_comb begin
    hi = duty_vec[0];
    lo = duty_vec[0];
    for (int t = 1; t < NUM_THREADS; t++) begin
      if (duty_vec[t] > hi) hi = duty_vec[t];
      if (duty_vec[t] < lo) lo = duty_vec[t];
    end
  end

  assign req_duty   = pol_max ? hi : lo;
  assign req_active = (&en_vec) && (req_duty != '0);
endmodule

// File: rtl/clkmod_window.sv
module clkmod_window
  import clkmod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_active,
  input  logic [DUTY_W-1:0] req_duty,
  output logic              clk_en,
  output logic              cur_active,
  output logic [DUTY_W-1:0] cur_duty
);
  logic [DUTY_W-1:0] phase;
  logic              last;

  assign last = (phase == DUTY_W'(WIN_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= '0;
      cur_active <= 1'b0;
      cur_duty   <= '0;
    end else begin
      phase <= phase + 1'b1;
      if (last) begin
        cur_active <= req_active;
        cur_duty   <= req_active ? req_duty : '0;
      end
    end
  end

  assign clk_en = !cur_active || (phase < cur_duty);
endmodule

// File: rtl/clkmod_ctrl.sv
module clkmod_ctrl
  import clkmod_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_cap,
  input  logic              pol_max,
  input  logic              wr_en,
  input  logic [TID_W-1:0]  wr_tid,
  input  logic [7:0]        wr_data,
  input  logic [TID_W-1:0]  rd_tid,
  output logic [7:0]        rd_data,
  output logic              clk_en,
  output logic              mod_active,
  output logic [3:0]        eff_duty
);
  logic [NUM_THREADS-1:0]             en_vec;
  logic [NUM_THREADS-1:0][DUTY_W-1:0] duty_vec;
  logic                               req_active;
  logic [DUTY_W-1:0]                  req_duty;

  clkmod_regfile #(.NUM_THREADS(NUM_THREADS)) u_regs (
    .clk(clk), .rst_n(rst_n), .ext_cap(ext_cap),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_data(wr_data),
    .rd_tid(rd_tid), .rd_data(rd_data),
    .en_vec(en_vec), .duty_vec(duty_vec)
  );

  clkmod_merge #(.NUM_THREADS(NUM_THREADS)) u_merge (
    .pol_max(pol_max), .en_vec(en_vec), .duty_vec(duty_vec),
    .req_active(req_active), .req_duty(req_duty)
  );

  clkmod_window u_win (
    .clk(clk), .rst_n(rst_n),
    .req_active(req_active), .req_duty(req_duty),
    .clk_en(clk_en), .cur_active(mod_active), .cur_duty(eff_duty)
  );
endmodule

// File: rtl/clkmod_chk.sv
module clkmod_chk #(
  parameter int NUM_THREADS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_cap,
  input logic [7:0] rd_data,
  input logic       clk_en,
  input logic       mod_active,
  input logic [3:0] eff_duty
);
  logic [3:0] ph;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else        ph <= ph + 1'b1;
  end

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:5] == 3'b000);

  assert_fine_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cap |-> !rd_data[0]);

  assert_idle_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_active |-> clk_en);

  assert_zero_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mod_active |-> eff_duty != 4'd0);

  assert_low_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 4'd0 && !$past(clk_en)) |-> !clk_en);

  assert_first_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == 4'd0) |-> clk_en);

  assert_boundary_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != 4'd0) |-> ($stable(mod_active) && $stable(eff_duty)));
endmodule

bind clkmod_ctrl clkmod_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_cap(ext_cap), .rd_data(rd_data),
  .clk_en(clk_en), .mod_active(mod_active), .eff_duty(eff_duty)
);

// File: tb/sim_clkmod_ctrl.sv
`timescale 1ns/1ps
module sim_clkmod_ctrl;
  localparam int NT = 2;
  localparam int TW = 1;

  logic clk = 0, rst_n = 0, ext_cap = 1, pol_max = 1, wr_en = 0;
  logic [TW-1:0] wr_tid = '0, rd_tid = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic clk_en, mod_active;
  logic [3:0] eff_duty;

  always #2 clk = ~clk;

  clkmod_ctrl #(.NUM_THREADS(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_cap(ext_cap), .pol_max(pol_max),
    .wr_en(wr_en), .wr_tid(wr_tid), .wr_data(wr_data), .rd_tid(rd_tid),
    .rd_data(rd_data), .clk_en(clk_en), .mod_active(mod_active), .eff_duty(eff_duty)
  );

  typedef struct { logic [15:0] pat; logic act; logic [3:0] duty; string tag; } item_t;
  item_t sb[$];

  int total = 0, bad = 0, bc = 0;
  bit done = 0;
  string cur_tag = "R10";
  logic [4:0] mir [NT];
  logic [15:0] samp;

  // model: window setting taken from mirror just before the boundary edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NT; t++) mir[t] = '0;
      bc = 0;
      if (sb.size() == 0) sb.push_back('{16'hFFFF, 1'b0, 4'd0, "R10"});
    end else begin
      if (bc % 16 == 15) begin
        item_t it;
        logic all_en;
        logic [3:0] d, hi, lo, sel;
        all_en = 1; hi = 0; lo = 4'hF;
        for (int t = 0; t < NT; t++) begin
          all_en &= mir[t][4];
          d = {mir[t][3:1], ext_cap ? mir[t][0] : 1'b0};
          if (d > hi) hi = d;
          if (d < lo) lo = d;
        end
        sel = pol_max ? hi : lo;
        it.act = all_en && sel != 0;
        it.duty = it.act ? sel : 4'd0;
        for (int i = 0; i < 16; i++) it.pat[i] = !it.act || (i < it.duty);
        it.tag = cur_tag;
        sb.push_back(it);
      end
      if (wr_en) mir[wr_tid] = {wr_data[4:1], ext_cap & wr_data[0]};
      bc++;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      samp[bc % 16] = clk_en;
      if (bc % 16 == 15) begin
        item_t e;
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL %s: window with no expected entry, got pat=%h exp=none", cur_tag, samp);
        end else begin
          e = sb.pop_front();
          if (samp !== e.pat || mod_active !== e.act || eff_duty !== e.duty) begin
            bad++;
            $display("FAIL %s R8: pat=%h act=%0b duty=%0d exp pat=%h act=%0b duty=%0d",
                     e.tag, samp, mod_active, eff_duty, e.pat, e.act, e.duty);
          end
        end
      end
    end
  end

  task automatic wr(input int tid, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_tid = TW'(tid); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic chk_rd(input int tid, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_tid = TW'(tid);
    #0.5;
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: rd thread %0d got %h exp %h", tag, tid, rd_data, exp);
    end
  endtask

  task automatic wait_win(input int n);
    repeat (16 * n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #50000;
    bad++; total++;
    $display("FAIL watchdog: run hung, got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    total++;
    if (clk_en !== 1'b1 || mod_active !== 1'b0) begin
      bad++; $display("FAIL R10: clk_en=%b act=%b exp 1 0", clk_en, mod_active);
    end
    rst_n = 1;
    chk_rd(0, 8'h00, "R10");
    chk_rd(1, 8'h00, "R10");

    // R1/R2/R5: thread 1 not enabled, reserved bits dropped
    cur_tag = "R5";
    ext_cap = 1; pol_max = 1;
    wr(0, 8'h1A);
    wr(1, 8'hE7);
    chk_rd(0, 8'h1A, "R1");
    chk_rd(1, 8'h07, "R2");
    wait_win(2);

    // R6: policy max then min (duties 10 and 7)
    cur_tag = "R6";
    wr(1, 8'h17);
    wait_win(2);
    pol_max = 0;
    wait_win(2);

    // R3: coarse mode, bit 0 dropped
    cur_tag = "R3";
    ext_cap = 0; pol_max = 1;
    wr(0, 8'h1B);
    wr(1, 8'h13);
    chk_rd(0, 8'h1A, "R3");
    chk_rd(1, 8'h12, "R3");
    wait_win(2);
    pol_max = 0;
    wait_win(2);

    // R7: zero duty in one thread with min policy
    cur_tag = "R7";
    ext_cap = 1;
    wr(0, 8'h10);
    wait_win(2);

    // R4: top fine duty 15
    cur_tag = "R4";
    wr(0, 8'h1F);
    wr(1, 8'h1F);
    wait_win(2);

    // R9: writes mid-window and on the last cycle before a boundary
    cur_tag = "R9";
    while (bc % 16 != 5) @(negedge clk);
    wr(0, 8'h11);
    wait_win(1);
    while (bc % 16 != 15) @(negedge clk);
    wr_en = 1; wr_tid = 1; wr_data = 8'h13;
    @(negedge clk);
    wr_en = 0;
    wait_win(2);
    chk_rd(1, 8'h13, "R9");

    // R5 again: drop enable on thread 0 while modulating
    cur_tag = "R5";
    wr(0, 8'h0F);
    wait_win(2);

    finish_run();
  end
endmodule